// File: doc/BRIEF.md
# Fuse-Configurable Programmable Logic Array

This block is a synthesizable model of a combinational programmable logic array. It has a set of dedicated inputs and a set of bidirectional pins. Every pin value, including the value seen on each bidirectional pin, enters an AND plane in both true and complement form. The AND plane forms a pool of shared logic product terms and one direction term per bidirectional pin. An OR plane lets any product term feed any number of outputs. Each output has a selectable polarity. Each direction term drives the tri-state enable of its own pin.

The personality of the block lives in a fuse map. Every map bit is one link, with 1 meaning the link is intact and 0 meaning it is removed. The map is shifted in serially, most significant bit first, into a shadow chain. The map takes effect only when the load enable falls, and it then stays static. From reset the array holds the unprogrammed state, with every link intact. A security link controls readback: while it is removed, the serial output reads all zeros.

The map layout from bit 0 upward is as follows, with NV = NUM_IN + NUM_IO variables and NUM_PT + NUM_IO terms:
- Bit 0 is the security link.
- Bits 1..NUM_IO hold the polarity links.
- Next come the OR links. The link from product term p to output o sits at 1 + NUM_IO + p*NUM_IO + o.
- Last come the AND links. Term t, variable v has its true link at AND_BASE + t*2*NV + 2*v and its complement link one bit above. Terms NUM_PT..NUM_PT+NUM_IO-1 are the direction terms of pins 0..NUM_IO-1.

Variables 0..NUM_IN-1 are the dedicated inputs. Variables NUM_IN..NV-1 are the bidirectional pin values.

Top module: `pla_fuse_array`

## Requirements
- R1: After a synchronous reset, the active map has every link intact. As a result, all io_oe bits are 0 and all io_out bits are 0 for every input pattern.
- R2: A product term is true only when, for every variable, the variable is 1 if its true link is intact and 0 if its complement link is intact. A variable with both links removed is a don't-care. A term with both links of any variable intact is always false.
- R3: Each output sums, by OR, exactly the logic product terms whose OR link to that output is intact. Any subset of the terms, from none to all, may be shared among all outputs.
- R4: With an output's polarity link intact, io_out equals the OR sum. With the link removed, io_out is the inverse of the sum.
- R5: io_oe of pin o equals direction term NUM_PT+o.
- R6: Bidirectional pin values on io_in feed the AND plane whatever the state of io_oe. Pin-to-output paths are combinational and need no clock edge.
- R7: While cfg_en is high, each clock edge shifts cfg_bit into the shadow chain. The first bit shifted lands at the map MSB. The active map keeps its old contents until the first edge at which cfg_en is low after having been high, and at that edge it takes the shadow contents.
- R8: cfg_dout presents the shadow MSB. Shifting the loaded map back in therefore returns its bits MSB first and leaves the map unchanged.
- R9: While the active security link (bit 0) is removed, cfg_dout is 0 and the logic function is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset to the unprogrammed map |
| cfg_en | input | 1 | Serial load enable; its falling edge applies the map |
| cfg_bit | input | 1 | Serial map data, MSB first |
| cfg_dout | output | 1 | Serial readback of the shadow MSB, blanked when secured |
| ded_in | input | NUM_IN | Dedicated inputs |
| io_in | input | NUM_IO | Values seen on the bidirectional pins |
| io_out | output | NUM_IO | Data driven toward the bidirectional pins |
| io_oe | output | NUM_IO | Per-pin output enable; 0 means high impedance |

## Verification
The assertions check several rules on every cycle:
- Any term with an intact link pair is false.
- An output with no active product term shows the inverse of its polarity link.
- The active map holds except on the release edge, and on that edge it copies the shadow.
- Readback follows the shift chain one cycle later.
- Enables and outputs are low right after reset.

Only the bench scenarios can show the full logic function against independently built random maps, the MSB-first bit order, the zero readback under security with unchanged logic, and the fact that outputs keep the old function throughout a reload.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int LINK_TRUE_OFS = 0;
  localparam int LINK_COMP_OFS = 1;

  // a variable lets a term pass unless an intact link demands the other value
  function automatic logic pair_pass(input logic true_link, input logic comp_link,
                                     input logic var_val);
    return (~true_link | var_val) & (~comp_link | ~var_val);
  endfunction
endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
  parameter int MAP_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_bit,
  output logic [MAP_W-1:0] active_map,
  output logic             cfg_dout
);
  logic [MAP_W-1:0] shadow_q;
  logic [MAP_W-1:0] active_q;
  logic             en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '1;
      active_q <= '1;
      en_q     <= 1'b0;
    end else begin
      en_q <= cfg_en;
      if (cfg_en) shadow_q <= {shadow_q[MAP_W-2:0], cfg_bit};
      if (en_q && !cfg_en) active_q <= shadow_q;
    end
  end

  assign active_map = active_q;
  assign cfg_dout   = active_q[0] & shadow_q[MAP_W-1];

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(en_q && !cfg_en) |=> $stable(active_q));

  assert_load_R7: assert property (@(posedge clk) disable iff (rst)
    (en_q && !cfg_en) |=> (active_q == $past(shadow_q)));

  assert_readback_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_en) && active_q[0] && $past(active_q[0]))
      |-> (cfg_dout == $past(shadow_q[MAP_W-2])));

  assert_secure_blank_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_dout |-> active_q[0]);
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int NV    = 22,
  parameter int TERMS = 42
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NV-1:0]         vars,
  input  logic [TERMS*2*NV-1:0] links,
  output logic [TERMS-1:0]      terms
);
  localparam int TERM_W = 2 * NV;

  for (genvar t = 0; t < TERMS; t++) begin : g_term
    logic [NV-1:0] tl;
    logic [NV-1:0] cl;
    logic [NV-1:0] pass;
    for (genvar v = 0; v < NV; v++) begin : g_var
      assign tl[v]   = links[t*TERM_W + 2*v + LINK_TRUE_OFS];
      assign cl[v]   = links[t*TERM_W + 2*v + LINK_COMP_OFS];
      assign pass[v] = pair_pass(tl[v], cl[v], vars[v]);
    end
    assign terms[t] = &pass;

    assert_inhibit_R2: assert property (@(posedge clk) disable iff (rst)
      (|(tl & cl)) |-> !terms[t]);
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int NUM_PT = 32,
  parameter int NUM_IO = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_PT-1:0]        lg_terms,
  input  logic [NUM_IO-1:0]        dir_terms,
  input  logic [NUM_PT*NUM_IO-1:0] or_links,
  input  logic [NUM_IO-1:0]        pol_links,
  output logic [NUM_IO-1:0]        io_out,
  output logic [NUM_IO-1:0]        io_oe
);
  for (genvar o = 0; o < NUM_IO; o++) begin : g_out
    logic [NUM_PT-1:0] hit;
    logic              sum;
    for (genvar p = 0; p < NUM_PT; p++) begin : g_pt
      assign hit[p] = lg_terms[p] & or_links[p*NUM_IO + o];
    end
    assign sum       = |hit;
    assign io_out[o] = pol_links[o] ? sum : ~sum;
  end

  assign io_oe = dir_terms;

  assert_idle_level_R3: assert property (@(posedge clk) disable iff (rst)
    (lg_terms == '0) |-> (io_out == ~pol_links));
endmodule

// File: rtl/pla_fuse_array.sv
module pla_fuse_array #(
  parameter int NUM_IN = 12,
  parameter int NUM_IO = 10,
  parameter int NUM_PT = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              cfg_bit,
  output logic              cfg_dout,
  input  logic [NUM_IN-1:0] ded_in,
  input  logic [NUM_IO-1:0] io_in,
  output logic [NUM_IO-1:0] io_out,
  output logic [NUM_IO-1:0] io_oe
);
  localparam int NV       = NUM_IN + NUM_IO;
  localparam int TERMS    = NUM_PT + NUM_IO;
  localparam int OR_BASE  = 1 + NUM_IO;
  localparam int AND_BASE = OR_BASE + NUM_PT * NUM_IO;
  localparam int MAP_W    = AND_BASE + TERMS * 2 * NV;

  logic [MAP_W-1:0] active_map;
  logic [TERMS-1:0] terms;
  logic [NV-1:0]    vars;

  assign vars = {io_in, ded_in};

  pla_cfg_chain #(.MAP_W(MAP_W)) i_cfg (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .active_map(active_map), .cfg_dout(cfg_dout)
  );

  pla_and_plane #(.NV(NV), .TERMS(TERMS)) i_and (
    .clk(clk), .rst(rst), .vars(vars),
    .links(active_map[AND_BASE +: TERMS*2*NV]), .terms(terms)
  );

  pla_or_plane #(.NUM_PT(NUM_PT), .NUM_IO(NUM_IO)) i_or (
    .clk(clk), .rst(rst),
    .lg_terms(terms[NUM_PT-1:0]), .dir_terms(terms[TERMS-1:NUM_PT]),
    .or_links(active_map[OR_BASE +: NUM_PT*NUM_IO]),
    .pol_links(active_map[NUM_IO:1]),
    .io_out(io_out), .io_oe(io_oe)
  );

  assert_virgin_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (io_oe == '0 && io_out == '0));
endmodule

// File: tb/test_pla_fuse_array.sv
module test_pla_fuse_array;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_IN   = 12;
  localparam int NUM_IO   = 10;
  localparam int NUM_PT   = 32;
  localparam int NV       = NUM_IN + NUM_IO;
  localparam int TERMS    = NUM_PT + NUM_IO;
  localparam int OR_BASE  = 1 + NUM_IO;
  localparam int AND_BASE = OR_BASE + NUM_PT * NUM_IO;
  localparam int MAP_W    = AND_BASE + TERMS * 2 * NV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en = 1'b0;
  logic cfg_bit = 1'b0;
  logic cfg_dout;
  logic [NUM_IN-1:0] ded_in = '0;
  logic [NUM_IO-1:0] io_in = '0;
  logic [NUM_IO-1:0] io_out;
  logic [NUM_IO-1:0] io_oe;

  int vectors = 0;
  int miscompares = 0;

  logic at_t [TERMS][NV];
  logic at_c [TERMS][NV];
  logic orl  [NUM_PT][NUM_IO];
  logic pol  [NUM_IO];
  logic sec;
  logic [MAP_W-1:0] cur_map;

  always #(CLK_PERIOD/2) clk = ~clk;

  pla_fuse_array #(.NUM_IN(NUM_IN), .NUM_IO(NUM_IO), .NUM_PT(NUM_PT)) i_pla_fuse_array (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_bit(cfg_bit), .cfg_dout(cfg_dout),
    .ded_in(ded_in), .io_in(io_in), .io_out(io_out), .io_oe(io_oe)
  );

  task automatic set_virgin();
    for (int t = 0; t < TERMS; t++)
      for (int v = 0; v < NV; v++) begin at_t[t][v] = 1'b1; at_c[t][v] = 1'b1; end
    for (int p = 0; p < NUM_PT; p++)
      for (int o = 0; o < NUM_IO; o++) orl[p][o] = 1'b1;
    for (int o = 0; o < NUM_IO; o++) pol[o] = 1'b1;
    sec = 1'b1;
  endtask

  task automatic gen_random(input logic secure_link);
    for (int t = 0; t < TERMS; t++) begin
      for (int v = 0; v < NV; v++) begin
        int r = int'($urandom % 16);
        at_t[t][v] = (r == 14);
        at_c[t][v] = (r == 15);
      end
      if ($urandom % 10 == 0) begin
        int v = int'($urandom % NV);
        at_t[t][v] = 1'b1;
        at_c[t][v] = 1'b1;
      end
    end
    for (int p = 0; p < NUM_PT; p++)
      for (int o = 0; o < NUM_IO; o++) orl[p][o] = ($urandom % 4 == 0);
    for (int o = 0; o < NUM_IO; o++) pol[o] = $urandom % 2;
    sec = secure_link;
  endtask

  function automatic logic [MAP_W-1:0] pack_map();
    logic [MAP_W-1:0] m = '0;
    m[0] = sec;
    for (int o = 0; o < NUM_IO; o++) m[1+o] = pol[o];
    for (int p = 0; p < NUM_PT; p++)
      for (int o = 0; o < NUM_IO; o++) m[OR_BASE + p*NUM_IO + o] = orl[p][o];
    for (int t = 0; t < TERMS; t++)
      for (int v = 0; v < NV; v++) begin
        m[AND_BASE + t*2*NV + 2*v]     = at_t[t][v];
        m[AND_BASE + t*2*NV + 2*v + 1] = at_c[t][v];
      end
    return m;
  endfunction

  task automatic ref_eval(output logic [NUM_IO-1:0] eo, output logic [NUM_IO-1:0] eoe);
    logic [NV-1:0] x = {io_in, ded_in};
    logic term [TERMS];
    for (int t = 0; t < TERMS; t++) begin
      term[t] = 1'b1;
      for (int v = 0; v < NV; v++) begin
        if (at_t[t][v] && !x[v]) term[t] = 1'b0;
        if (at_c[t][v] && x[v])  term[t] = 1'b0;
      end
    end
    for (int o = 0; o < NUM_IO; o++) begin
      logic s = 1'b0;
      for (int p = 0; p < NUM_PT; p++) if (term[p] && orl[p][o]) s = 1'b1;
      eo[o]  = pol[o] ? s : ~s;
      eoe[o] = term[NUM_PT + o];
    end
  endtask

  task automatic check_vec(input string tag);
    logic [NUM_IO-1:0] eo, eoe;
    ded_in = NUM_IN'($urandom);
    io_in  = NUM_IO'($urandom);
    #1;
    ref_eval(eo, eoe);
    vectors++;
    if (io_out !== eo || io_oe !== eoe) begin
      miscompares++;
      $display("FAIL %s in=%h io=%h: io_out=%h exp %h, io_oe=%h exp %h",
               tag, ded_in, io_in, io_out, eo, io_oe, eoe);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // shifts the map in; outputs must keep the old function until release (R7)
  task automatic load_map(input logic [MAP_W-1:0] m, input logic [NUM_IO-1:0] old_o,
                          input logic [NUM_IO-1:0] old_oe);
    cfg_en = 1'b1;
    for (int k = MAP_W-1; k >= 0; k--) begin
      cfg_bit = m[k];
      @(posedge clk); #1;
      if (k == MAP_W/2 || k == 0) begin
        vectors++;
        if (io_out !== old_o || io_oe !== old_oe) begin
          miscompares++;
          $display("FAIL R7 map changed during shift: io_out=%h exp %h io_oe=%h exp %h",
                   io_out, old_o, io_oe, old_oe);
        end
      end
    end
    cfg_en = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic readback(input logic [MAP_W-1:0] m, input logic blank, input string tag);
    int bad = 0;
    logic first_bad_exp = 1'b0;
    cfg_en = 1'b1;
    for (int k = MAP_W-1; k >= 0; k--) begin
      logic exp;
      cfg_bit = m[k];
      #1;
      exp = blank ? 1'b0 : m[k];
      if (cfg_dout !== exp) begin
        if (bad == 0) first_bad_exp = exp;
        bad++;
      end
      @(posedge clk); #1;
    end
    cfg_en = 1'b0;
    @(posedge clk); #1;
    vectors++;
    if (bad != 0) begin
      miscompares++;
      $display("FAIL %s: %0d readback bits wrong, first actual %b expected %b",
               tag, bad, ~first_bad_exp, first_bad_exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [NUM_IO-1:0] oo, ooe;
    set_virgin();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    // R1: unprogrammed state after reset
    for (int i = 0; i < 40; i++) check_vec("R1 virgin map");
    check_bit("R1 virgin io_oe all zero", io_oe == '0, 1'b1);
    check_bit("R8 virgin readback bit", cfg_dout, 1'b1);

    // random maps: R2 R3 R4 R5 R6 (combinational, no clock between vectors)
    for (int m = 0; m < 5; m++) begin
      ref_eval(oo, ooe);
      gen_random(1'b1);
      cur_map = pack_map();
      load_map(cur_map, oo, ooe);
      for (int i = 0; i < 400; i++) check_vec("R2 R3 R4 R5 R6 random map");
    end

    // all polarity links removed, every OR link intact: R3 R4 sharing
    ref_eval(oo, ooe);
    gen_random(1'b1);
    for (int o = 0; o < NUM_IO; o++) pol[o] = 1'b0;
    for (int p = 0; p < NUM_PT; p++)
      for (int o = 0; o < NUM_IO; o++) orl[p][o] = 1'b1;
    cur_map = pack_map();
    load_map(cur_map, oo, ooe);
    for (int i = 0; i < 300; i++) check_vec("R3 R4 full sharing inverted");

    // R8: circulating readback returns the map MSB first, map unchanged
    readback(cur_map, 1'b0, "R8 readback order");
    for (int i = 0; i < 100; i++) check_vec("R8 map intact after readback");

    // R9: security link removed blanks readback, logic unchanged
    ref_eval(oo, ooe);
    gen_random(1'b0);
    cur_map = pack_map();
    load_map(cur_map, oo, ooe);
    for (int i = 0; i < 300; i++) check_vec("R9 secured logic");
    readback(cur_map, 1'b1, "R9 secured readback");
    for (int i = 0; i < 100; i++) check_vec("R9 secured logic after readback");

    finish_run();
  end
endmodule